// File: doc/BRIEF.md
# Dual-Issue Pairing Check for an Integer/FP Front End

This block decides, cycle by cycle, how much of a fetched instruction pair may issue in a two-way in-order front end. Each cycle fetch presents one aligned 64-bit pair. The left slot carries an integer, memory or branch instruction and the right slot carries a floating-point operation. The block decodes both opcodes and all six register fields. It compares the source registers against a scoreboard supplied from outside and against a one-cycle record of the most recent load. It then issues nothing, the left slot alone, or both slots, and it asks fetch to hold the pair whenever part of it is still waiting.

When the right slot cannot go with its partner, the left instruction issues on its own. The same pair is presented again on the next cycle and the block treats it as a lone right-slot instruction. A load issued in the left slot is unusable by three instruction slots: its own right partner and both slots of the pair that issues on the next cycle. A taken branch in the left slot discards the next valid pair fetched after the branch pair completes.

Top module: `dual_issue_pair_check`

## Requirements
- R1: After reset, no issue or hold is signalled while no pair is offered, and the first legal pair issues in full. Reset clears the load record, the deferred-right state and the pending discard.
- R2: Encoding: opcode in bits 31:26, destination in 25:21, first source in 20:16, second source in 15:11. Opcodes: 0x00 empty; 0x01 integer ALU (int dest, int src1, int src2); 0x02 integer load (int dest, int src1); 0x03 FP load (FP dest, int src1); 0x04 branch (int src1, int src2); 0x05 FP store (int src1, FP src2); 0x10 FP operation (FP dest, FP src1, FP src2). Any other opcode reads and writes no register and counts as non-FP.
- R3: A pair with a non-FP left instruction, an FP-operation right instruction and no hazard issues both slots in the same cycle, and hold stays low.
- R4: The right slot never issues ahead of the left slot of its pair. If the left instruction has a hazard, neither slot issues and hold is high.
- R5: If the right slot is not an FP operation, or the left slot is an FP operation, the left slot issues alone with hold high. On the next cycle the re-presented pair issues only its right instruction, which is then subject only to its own hazards.
- R6: An empty right slot (opcode 0x00) lets the left instruction issue alone with hold low.
- R7: A source register that is marked busy in the integer or FP scoreboard input blocks the instruction that reads it.
- R8: A right-slot instruction that reads the destination of a load in the left slot of the same pair does not issue in that cycle.
- R9: In the cycle after a load issues, any instruction in either slot that reads the load's destination is blocked. Two cycles after the load, the destination may be read.
- R10: An FP load in the left slot and an FP operation in the right slot, with no shared register, issue together.
- R11: When a left-slot branch issues with the taken input high, the next valid pair after the branch pair completes is discarded: no issue and no hold. The pair after that one issues normally. With the taken input low, nothing is discarded.
- R12: While no pair is offered, no issue and no hold are signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pair_valid_i | input | 1 | A fetched pair is offered this cycle |
| left_insn_i | input | 32 | Left-slot instruction (integer, memory or branch) |
| right_insn_i | input | 32 | Right-slot instruction (FP operation expected) |
| branch_taken_i | input | 1 | Outcome of a branch in the left slot of the offered pair |
| int_busy_i | input | 32 | Integer scoreboard, one busy bit per register |
| fp_busy_i | input | 32 | FP scoreboard, one busy bit per register |
| issue_left_o | output | 1 | Left instruction issues this cycle |
| issue_right_o | output | 1 | Right instruction issues this cycle |
| fetch_hold_o | output | 1 | Fetch must present the same pair again |

## Verification
The hardest case to reach is a load whose delay window meets a deferred right slot. Here the right instruction reads the load result, is refused in the load's own cycle, returns alone on the next cycle while the load record is still live, and issues only on the third cycle. The stimulus holds one pair with an FP load on the left and a dependent FP operation on the right for three cycles, with both scoreboards clear. Each cycle is then checked against the expected pattern. A taken branch whose right partner is deferred is driven the same way, so the discard has to skip the re-presented pair and land on the pair after it.

// File: rtl/pair_pkg.sv
`timescale 1ns/1ps
// pair_pkg: shared encoding constants and decoded-slot types for the
// dual-issue pairing check. Assumes fixed 32-bit instructions with
// register fields at fixed positions.
package pair_pkg;
    localparam int INSN_W  = 32;
    localparam int OP_W    = 6;
    localparam int REG_W   = 5;
    localparam int NREG    = 1 << REG_W;
    localparam int OP_LSB  = INSN_W - OP_W;
    localparam int RD_LSB  = OP_LSB - REG_W;
    localparam int RS1_LSB = RD_LSB - REG_W;
    localparam int RS2_LSB = RS1_LSB - REG_W;

    localparam logic [OP_W-1:0] OP_EMPTY  = 6'h00;
    localparam logic [OP_W-1:0] OP_IALU   = 6'h01;
    localparam logic [OP_W-1:0] OP_ILOAD  = 6'h02;
    localparam logic [OP_W-1:0] OP_FLOAD  = 6'h03;
    localparam logic [OP_W-1:0] OP_BRANCH = 6'h04;
    localparam logic [OP_W-1:0] OP_FSTORE = 6'h05;
    localparam logic [OP_W-1:0] OP_FOP    = 6'h10;

    // One register reference: used flag, register file select, index.
    typedef struct packed {
        logic             v;
        logic             fp;
        logic [REG_W-1:0] idx;
    } reg_ref_t;

    // Decoded view of one slot.
    typedef struct packed {
        reg_ref_t src1;
        reg_ref_t src2;
        reg_ref_t dst;
        logic     is_load;
        logic     is_branch;
        logic     is_fpop;
        logic     is_empty;
    } slot_dec_t;
endpackage

// File: rtl/slot_decode.sv
`timescale 1ns/1ps
// slot_decode: turns one instruction word into register references and
// class flags. Purely combinational. Unknown opcodes use no registers.
module slot_decode
    import pair_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    output slot_dec_t         dec_o
);
    logic [OP_W-1:0]  op;
    logic [REG_W-1:0] rd, rs1, rs2;
    logic             unused_low;

    assign op  = insn_i[OP_LSB  +: OP_W];
    assign rd  = insn_i[RD_LSB  +: REG_W];
    assign rs1 = insn_i[RS1_LSB +: REG_W];
    assign rs2 = insn_i[RS2_LSB +: REG_W];
    assign unused_low = ^insn_i[RS2_LSB-1:0];

    // Map the opcode onto source, destination and class information.
    always_comb begin
        dec_o = '0;
        unique case (op)
            OP_EMPTY: dec_o.is_empty = 1'b1;
            OP_IALU: begin
                dec_o.dst  = '{v: 1'b1, fp: 1'b0, idx: rd};
                dec_o.src1 = '{v: 1'b1, fp: 1'b0, idx: rs1};
                dec_o.src2 = '{v: 1'b1, fp: 1'b0, idx: rs2};
            end
            OP_ILOAD: begin
                dec_o.dst     = '{v: 1'b1, fp: 1'b0, idx: rd};
                dec_o.src1    = '{v: 1'b1, fp: 1'b0, idx: rs1};
                dec_o.is_load = 1'b1;
            end
            OP_FLOAD: begin
                dec_o.dst     = '{v: 1'b1, fp: 1'b1, idx: rd};
                dec_o.src1    = '{v: 1'b1, fp: 1'b0, idx: rs1};
                dec_o.is_load = 1'b1;
            end
            OP_BRANCH: begin
                dec_o.src1      = '{v: 1'b1, fp: 1'b0, idx: rs1};
                dec_o.src2      = '{v: 1'b1, fp: 1'b0, idx: rs2};
                dec_o.is_branch = 1'b1;
            end
            OP_FSTORE: begin
                dec_o.src1 = '{v: 1'b1, fp: 1'b0, idx: rs1};
                dec_o.src2 = '{v: 1'b1, fp: 1'b1, idx: rs2};
            end
            OP_FOP: begin
                dec_o.dst     = '{v: 1'b1, fp: 1'b1, idx: rd};
                dec_o.src1    = '{v: 1'b1, fp: 1'b1, idx: rs1};
                dec_o.src2    = '{v: 1'b1, fp: 1'b1, idx: rs2};
                dec_o.is_fpop = 1'b1;
            end
            default: dec_o = '0;
        endcase
    end
endmodule

// File: rtl/hazard_unit.sv
`timescale 1ns/1ps
// hazard_unit: computes per-slot read hazards from the scoreboards, the
// one-cycle load record and the same-pair load result. Assumes a load
// result can be read two cycles after the load issues.
module hazard_unit
    import pair_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  reg_ref_t        l_src1_i,
    input  reg_ref_t        l_src2_i,
    input  reg_ref_t        l_dst_i,
    input  logic            l_is_load_i,
    input  reg_ref_t        r_src1_i,
    input  reg_ref_t        r_src2_i,
    input  logic            left_done_i,
    input  logic            issue_left_i,
    input  logic [NREG-1:0] int_busy_i,
    input  logic [NREG-1:0] fp_busy_i,
    output logic            left_haz_o,
    output logic            right_haz_o
);
    reg_ref_t pend_q;

    // Scoreboard or load-record conflict for one source.
    function automatic logic src_blocked(input reg_ref_t s, input reg_ref_t p,
                                         input logic [NREG-1:0] ib,
                                         input logic [NREG-1:0] fb);
        logic busy;
        busy = s.fp ? fb[s.idx] : ib[s.idx];
        return s.v && (busy || (p.v && p.fp == s.fp && p.idx == s.idx));
    endfunction

    // Conflict of a right source with a load in the same pair's left slot.
    function automatic logic pair_hit(input reg_ref_t s, input reg_ref_t d,
                                      input logic ld, input logic done);
        return !done && ld && d.v && s.v && s.fp == d.fp && s.idx == d.idx;
    endfunction

    // Record the destination of a load for exactly one cycle after it issues.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else if (issue_left_i && l_is_load_i)
            pend_q <= l_dst_i;
        else
            pend_q <= '0;
    end

    // Combine all read hazards per slot.
    always_comb begin
        left_haz_o  = src_blocked(l_src1_i, pend_q, int_busy_i, fp_busy_i)
                    | src_blocked(l_src2_i, pend_q, int_busy_i, fp_busy_i);
        right_haz_o = src_blocked(r_src1_i, pend_q, int_busy_i, fp_busy_i)
                    | src_blocked(r_src2_i, pend_q, int_busy_i, fp_busy_i)
                    | pair_hit(r_src1_i, l_dst_i, l_is_load_i, left_done_i)
                    | pair_hit(r_src2_i, l_dst_i, l_is_load_i, left_done_i);
    end
endmodule

// File: rtl/issue_arbiter.sv
`timescale 1ns/1ps
// issue_arbiter: chooses none, left-only or both slots, tracks a deferred
// right slot and arms the discard after a taken branch. Assumes fetch
// re-presents the same pair while hold is high.
module issue_arbiter (
    input  logic clk,
    input  logic rst_n,
    input  logic pair_valid_i,
    input  logic l_is_fpop_i,
    input  logic l_is_branch_i,
    input  logic r_is_fpop_i,
    input  logic r_is_empty_i,
    input  logic left_haz_i,
    input  logic right_haz_i,
    input  logic branch_taken_i,
    output logic issue_left_o,
    output logic issue_right_o,
    output logic fetch_hold_o,
    output logic left_done_o
);
    logic left_done_q, taken_q, squash_q;
    logic done_pair, defer, taken_now;

    assign left_done_o = left_done_q;

    // Issue decision for the offered pair.
    always_comb begin
        issue_left_o  = 1'b0;
        issue_right_o = 1'b0;
        fetch_hold_o  = 1'b0;
        done_pair     = 1'b0;
        defer         = 1'b0;
        if (pair_valid_i && !squash_q) begin
            if (left_done_q) begin
                if (right_haz_i) fetch_hold_o = 1'b1;
                else begin
                    issue_right_o = 1'b1;
                    done_pair     = 1'b1;
                end
            end else if (left_haz_i) begin
                fetch_hold_o = 1'b1;
            end else begin
                issue_left_o = 1'b1;
                if (r_is_empty_i) done_pair = 1'b1;
                else if (r_is_fpop_i && !l_is_fpop_i && !right_haz_i) begin
                    issue_right_o = 1'b1;
                    done_pair     = 1'b1;
                end else begin
                    fetch_hold_o = 1'b1;
                    defer        = 1'b1;
                end
            end
        end
        taken_now = issue_left_o && l_is_branch_i && branch_taken_i;
    end

    // Deferred-right, taken-branch and discard state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_done_q <= 1'b0;
            taken_q     <= 1'b0;
            squash_q    <= 1'b0;
        end else begin
            if (defer) left_done_q <= 1'b1;
            else if (done_pair) left_done_q <= 1'b0;
            if (defer && taken_now) taken_q <= 1'b1;
            else if (done_pair) taken_q <= 1'b0;
            if (done_pair && (taken_q || taken_now)) squash_q <= 1'b1;
            else if (pair_valid_i) squash_q <= 1'b0;
        end
    end

    a_r4_right_needs_left: assert property (@(posedge clk) disable iff (!rst_n)
        issue_right_o |-> (issue_left_o || left_done_q));
    a_r4_left_hazard_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid_i && !squash_q && !left_done_q && left_haz_i)
        |-> (!issue_left_o && !issue_right_o && fetch_hold_o));
    a_r5_slot_roles: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_right_o && !left_done_q) |-> (r_is_fpop_i && !l_is_fpop_i));
    a_r5_resume_single: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_left_o && fetch_hold_o && pair_valid_i) |=> (pair_valid_i -> !issue_left_o));
    a_r11_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid_i && squash_q) |-> (!issue_left_o && !issue_right_o && !fetch_hold_o));
    a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_valid_i |-> (!issue_left_o && !issue_right_o && !fetch_hold_o));
endmodule

// File: rtl/dual_issue_pair_check.sv
`timescale 1ns/1ps
// dual_issue_pair_check: top of the pairing check. Decodes both slots,
// evaluates hazards and drives the issue and hold outputs. Assumes left
// slot = integer/memory/branch, right slot = FP operation.
module dual_issue_pair_check
    import pair_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pair_valid_i,
    input  logic [INSN_W-1:0] left_insn_i,
    input  logic [INSN_W-1:0] right_insn_i,
    input  logic              branch_taken_i,
    input  logic [NREG-1:0]   int_busy_i,
    input  logic [NREG-1:0]   fp_busy_i,
    output logic              issue_left_o,
    output logic              issue_right_o,
    output logic              fetch_hold_o
);
    localparam int NSLOT = 2;

    logic [INSN_W-1:0] insn [NSLOT];
    slot_dec_t         dec  [NSLOT];
    logic              left_haz, right_haz, left_done;
    logic              unused_dec;

    assign insn[0] = left_insn_i;
    assign insn[1] = right_insn_i;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        slot_decode u_dec (.insn_i(insn[s]), .dec_o(dec[s]));
    end

    assign unused_dec = dec[0].is_empty ^ dec[1].is_load ^ dec[1].is_branch ^ (^dec[1].dst);

    hazard_unit u_haz (
        .clk(clk), .rst_n(rst_n),
        .l_src1_i(dec[0].src1), .l_src2_i(dec[0].src2), .l_dst_i(dec[0].dst),
        .l_is_load_i(dec[0].is_load),
        .r_src1_i(dec[1].src1), .r_src2_i(dec[1].src2),
        .left_done_i(left_done), .issue_left_i(issue_left_o),
        .int_busy_i(int_busy_i), .fp_busy_i(fp_busy_i),
        .left_haz_o(left_haz), .right_haz_o(right_haz)
    );

    issue_arbiter u_arb (
        .clk(clk), .rst_n(rst_n), .pair_valid_i(pair_valid_i),
        .l_is_fpop_i(dec[0].is_fpop), .l_is_branch_i(dec[0].is_branch),
        .r_is_fpop_i(dec[1].is_fpop), .r_is_empty_i(dec[1].is_empty),
        .left_haz_i(left_haz), .right_haz_i(right_haz),
        .branch_taken_i(branch_taken_i),
        .issue_left_o(issue_left_o), .issue_right_o(issue_right_o),
        .fetch_hold_o(fetch_hold_o), .left_done_o(left_done)
    );

    a_r8_no_same_pair_load_use: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_left_o && issue_right_o && dec[0].is_load)
        |-> (dec[1].src1 != dec[0].dst && dec[1].src2 != dec[0].dst));
    a_r9_next_cycle_load_use: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_left_o && dec[0].is_load)
        |=> !((issue_left_o && (dec[0].src1 == $past(dec[0].dst) || dec[0].src2 == $past(dec[0].dst)))
           || (issue_right_o && (dec[1].src1 == $past(dec[0].dst) || dec[1].src2 == $past(dec[0].dst)))));
    a_r7_busy_blocks_left: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_left_o && dec[0].src1.v && !dec[0].src1.fp) |-> !int_busy_i[dec[0].src1.idx]);
endmodule

// File: tb/tb_dual_issue_pair_check.sv
`timescale 1ns/1ps
module tb_dual_issue_pair_check;
    import pair_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pair_valid = 1'b0;
    logic [INSN_W-1:0] left_insn = '0, right_insn = '0;
    logic              br_taken = 1'b0;
    logic [NREG-1:0]   int_busy = '0, fp_busy = '0;
    logic              il, ir, hold;
    int                n_checks = 0, n_fail = 0;

    always #2 clk = ~clk;

    dual_issue_pair_check dut (
        .clk(clk), .rst_n(rst_n), .pair_valid_i(pair_valid),
        .left_insn_i(left_insn), .right_insn_i(right_insn),
        .branch_taken_i(br_taken), .int_busy_i(int_busy), .fp_busy_i(fp_busy),
        .issue_left_o(il), .issue_right_o(ir), .fetch_hold_o(hold)
    );

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rd,
                                       input logic [4:0] a, input logic [4:0] b);
        return {op, rd, a, b, 11'b0};
    endfunction

    // Present inputs after the falling edge, settle, leave room to check.
    task automatic drive(input logic v, input logic [31:0] l, input logic [31:0] r,
                         input logic bt, input logic [NREG-1:0] ib, input logic [NREG-1:0] fb);
        @(negedge clk);
        pair_valid = v; left_insn = l; right_insn = r; br_taken = bt;
        int_busy = ib; fp_busy = fb;
        #1;
    endtask

    task automatic expect3(input logic el, input logic er, input logic eh, input string req);
        n_checks++;
        if (il !== el || ir !== er || hold !== eh) begin
            n_fail++;
            $display("FAIL %s: got left=%b right=%b hold=%b expected left=%b right=%b hold=%b",
                     req, il, ir, hold, el, er, eh);
        end
    endtask

    task automatic idle();
        drive(1'b0, '0, '0, 1'b0, '0, '0);
    endtask

    task automatic t_reset();
        idle();
        expect3(0, 0, 0, "R1 idle after reset");
        drive(1'b1, mk(OP_IALU, 1, 2, 3), mk(OP_FOP, 1, 2, 3), 1'b0, '0, '0);
        expect3(1, 1, 0, "R1 first pair issues");
        drive(1'b0, mk(OP_IALU, 1, 2, 3), mk(OP_FOP, 1, 2, 3), 1'b0, '0, '0);
        expect3(0, 0, 0, "R12 no pair offered");
    endtask

    task automatic t_pair();
        drive(1'b1, mk(OP_FSTORE, 0, 4, 9), mk(OP_FOP, 6, 7, 8), 1'b0, '0, '0);
        expect3(1, 1, 0, "R3 store plus fp op");
        drive(1'b1, mk(OP_IALU, 5, 6, 7), mk(OP_EMPTY, 0, 0, 0), 1'b0, '0, '0);
        expect3(1, 0, 0, "R6 empty right slot");
        drive(1'b1, mk(6'h3f, 0, 0, 0), mk(OP_FOP, 3, 4, 5), 1'b0, '0, '0);
        expect3(1, 1, 0, "R2 unknown opcode is non-FP");
        idle();
    endtask

    task automatic t_misfit();
        drive(1'b1, mk(OP_FOP, 1, 2, 3), mk(OP_FOP, 4, 5, 6), 1'b0, '0, '0);
        expect3(1, 0, 1, "R5 fp op on left");
        drive(1'b1, mk(OP_FOP, 1, 2, 3), mk(OP_FOP, 4, 5, 6), 1'b0, '0, '0);
        expect3(0, 1, 0, "R5 right resumes alone");
        drive(1'b1, mk(OP_IALU, 1, 2, 3), mk(OP_IALU, 4, 5, 6), 1'b0, '0, '0);
        expect3(1, 0, 1, "R5 integer on right");
        drive(1'b1, mk(OP_IALU, 1, 2, 3), mk(OP_IALU, 4, 5, 6), 1'b0, '0, '0);
        expect3(0, 1, 0, "R5 integer right resumes");
        idle();
    endtask

    task automatic t_busy();
        drive(1'b1, mk(OP_IALU, 1, 2, 3), mk(OP_FOP, 4, 5, 6), 1'b0, 32'h4, '0);
        expect3(0, 0, 1, "R4 R7 left source busy");
        drive(1'b1, mk(OP_IALU, 1, 2, 3), mk(OP_FOP, 4, 5, 6), 1'b0, '0, '0);
        expect3(1, 1, 0, "R7 busy cleared");
        drive(1'b1, mk(OP_IALU, 1, 2, 3), mk(OP_FOP, 4, 5, 6), 1'b0, '0, 32'h20);
        expect3(1, 0, 1, "R7 right fp source busy");
        drive(1'b1, mk(OP_IALU, 1, 2, 3), mk(OP_FOP, 4, 5, 6), 1'b0, '0, 32'h20);
        expect3(0, 0, 1, "R7 right still busy");
        drive(1'b1, mk(OP_IALU, 1, 2, 3), mk(OP_FOP, 4, 5, 6), 1'b0, '0, '0);
        expect3(0, 1, 0, "R7 right issues once clear");
        idle();
    endtask

    task automatic t_load_same_pair();
        drive(1'b1, mk(OP_FLOAD, 4, 1, 0), mk(OP_FOP, 6, 4, 2), 1'b0, '0, '0);
        expect3(1, 0, 1, "R8 same-pair load use");
        drive(1'b1, mk(OP_FLOAD, 4, 1, 0), mk(OP_FOP, 6, 4, 2), 1'b0, '0, '0);
        expect3(0, 0, 1, "R9 deferred right still in window");
        drive(1'b1, mk(OP_FLOAD, 4, 1, 0), mk(OP_FOP, 6, 4, 2), 1'b0, '0, '0);
        expect3(0, 1, 0, "R9 readable two cycles later");
        idle();
    endtask

    task automatic t_load_next_pair();
        drive(1'b1, mk(OP_ILOAD, 7, 1, 0), mk(OP_FOP, 1, 2, 3), 1'b0, '0, '0);
        expect3(1, 1, 0, "R9 int load pair");
        drive(1'b1, mk(OP_IALU, 8, 7, 2), mk(OP_FOP, 4, 5, 6), 1'b0, '0, '0);
        expect3(0, 0, 1, "R9 next left blocked");
        drive(1'b1, mk(OP_IALU, 8, 7, 2), mk(OP_FOP, 4, 5, 6), 1'b0, '0, '0);
        expect3(1, 1, 0, "R9 next left released");
        drive(1'b1, mk(OP_FLOAD, 10, 1, 0), mk(OP_FOP, 11, 12, 13), 1'b0, '0, '0);
        expect3(1, 1, 0, "R10 fp load pairs with fp op");
        drive(1'b1, mk(OP_IALU, 2, 3, 4), mk(OP_FOP, 14, 10, 15), 1'b0, '0, '0);
        expect3(1, 0, 1, "R9 next right blocked");
        drive(1'b1, mk(OP_IALU, 2, 3, 4), mk(OP_FOP, 14, 10, 15), 1'b0, '0, '0);
        expect3(0, 1, 0, "R9 next right released");
        idle();
    endtask

    task automatic t_branch();
        drive(1'b1, mk(OP_BRANCH, 0, 1, 2), mk(OP_FOP, 1, 2, 3), 1'b0, '0, '0);
        expect3(1, 1, 0, "R11 not-taken branch pair");
        drive(1'b1, mk(OP_IALU, 1, 2, 3), mk(OP_FOP, 1, 2, 3), 1'b0, '0, '0);
        expect3(1, 1, 0, "R11 no discard when not taken");
        drive(1'b1, mk(OP_BRANCH, 0, 1, 2), mk(OP_FOP, 1, 2, 3), 1'b1, '0, '0);
        expect3(1, 1, 0, "R11 taken branch pair");
        idle();
        drive(1'b1, mk(OP_IALU, 1, 2, 3), mk(OP_FOP, 1, 2, 3), 1'b0, '0, '0);
        expect3(0, 0, 0, "R11 next valid pair discarded");
        drive(1'b1, mk(OP_IALU, 1, 2, 3), mk(OP_FOP, 1, 2, 3), 1'b0, '0, '0);
        expect3(1, 1, 0, "R11 following pair issues");
        drive(1'b1, mk(OP_BRANCH, 0, 1, 2), mk(OP_IALU, 1, 2, 3), 1'b1, '0, '0);
        expect3(1, 0, 1, "R11 taken branch with deferred right");
        drive(1'b1, mk(OP_BRANCH, 0, 1, 2), mk(OP_IALU, 1, 2, 3), 1'b0, '0, '0);
        expect3(0, 1, 0, "R11 deferred right not discarded");
        drive(1'b1, mk(OP_IALU, 1, 2, 3), mk(OP_FOP, 1, 2, 3), 1'b0, '0, '0);
        expect3(0, 0, 0, "R11 discard after deferred pair");
        drive(1'b1, mk(OP_IALU, 1, 2, 3), mk(OP_FOP, 1, 2, 3), 1'b0, '0, '0);
        expect3(1, 1, 0, "R11 resume after discard");
        idle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pair();
        t_misfit();
        t_busy();
        t_load_same_pair();
        t_load_next_pair();
        t_branch();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #40000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule